// File: doc/BRIEF.md
# Dual-Clock Fixed-Frame Sample Multiplexer

This block takes one sample record per cycle of a slow system clock and hands it to a fast serializer clock that is not related to it. Each record holds eight 7-bit channel codes, one shared 2-bit capacitor-ID field and 14 header bits. Examples of header bits are the mode flag, the beam markers, the data tag, the injection marker and the timing count. The header is carried as an opaque field. Two consecutive records are packed into a fixed frame of five 32-bit words. The frame is streamed on the serializer clock. A data-valid output is low in every slot that carries no frame word, so the serializer can insert its idle character there.

The crossing uses a dual-clock FIFO of whole records with Gray-coded pointers. The read side starts a frame only when both of its records are present, and then sends the five words with no gap between them. A test-mode input replaces the channel codes with a counter, so latency through the system can be measured. A sticky flag in the system domain reports any record that was dropped because the FIFO was full.

Top module: `frame_mux`

## Requirements
- R1: The record data field is 58 bits, {capid, ch7..ch0}, with channel c at bits 7c+6..7c and capid at bits 57..56. A record is {hdr[13:0], data[57:0]}. For records A and B, the five words are sent in this order: rec A bits 31..0; rec A bits 63..32; {16 zero bits, hdr B[13:6], hdr A[13:6]}; rec B bits 31..0; rec B bits 63..32.
- R2: Once a frame's first word is valid, data-valid stays high for exactly five consecutive serializer cycles, one word per cycle.
- R3: Records 2n and 2n+1 after reset form frame n. Frames leave in capture order, and each record is sent exactly once. No record is lost while the FIFO has room.
- R4: When data-valid is low, the output word is all zeros.
- R5: In reset, data-valid is low, the word is zero and the overflow flag is low. After reset, the output stays idle until the first pair of records has been written.
- R6: When test mode is high, channel c carries (cnt + c) mod 128 and capid carries cnt[1:0]. cnt is 0 on the first system cycle after reset and rises by one every cycle. The header passes through unchanged.
- R7: The FIFO holds 8 records. With reads stalled, the first 8 records are kept. A write attempted while the FIFO is full drops the record and sets the overflow flag, which stays set until system reset. The stored records are not disturbed.
- R8: A frame starts only when both of its records are in the FIFO as seen by the read side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System sampling clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| test_mode | input | 1 | 1 = counter pattern replaces channel data |
| smp_code | input | 56 | Eight 7-bit channel codes, channel 0 in the low bits |
| smp_capid | input | 2 | Shared capacitor-ID bits |
| smp_hdr | input | 14 | Per-cycle header bits |
| ovf_flag | output | 1 | Sticky overflow indication, system domain |
| ser_clk | input | 1 | Serializer clock |
| ser_rst_n | input | 1 | Active-low asynchronous reset, serializer domain |
| ser_word | output | 32 | Frame word to the serializer |
| ser_valid | output | 1 | High when ser_word carries a frame word |

## Verification
A wrong pointer or a wrong word index shows at the ports within one frame. It appears as a word taken from the wrong record or from the wrong bit slice, a repeated or skipped pair, or a valid run that is not five long. Each of these breaks the word-by-word comparison against records computed from the sample index. A fault in the full detection or in the overflow flag shows once the read side is held in reset. The flag then rises on the ninth write, and the four frames drained afterwards must still be records 0 to 7.

// File: rtl/fmx_pkg.sv
package fmx_pkg;
    localparam int N_CH        = 8;
    localparam int CODE_W      = 7;
    localparam int CAP_W       = 2;
    localparam int HDR_W       = 14;
    localparam int WORD_W      = 32;
    localparam int FRAME_WORDS = 5;
    localparam int DATA_W      = N_CH * CODE_W + CAP_W;
    localparam int REC_W       = DATA_W + HDR_W;
    localparam int SPLIT_LO    = 2 * WORD_W;
    localparam int TAIL_W      = REC_W - SPLIT_LO;
    localparam int PAD_W       = WORD_W - 2 * TAIL_W;
    localparam int IDX_W       = $clog2(FRAME_WORDS);

    typedef struct packed {
        logic [HDR_W-1:0]  hdr;
        logic [DATA_W-1:0] data;
    } rec_t;

    function automatic logic [WORD_W-1:0] pick_word(input rec_t a, input rec_t b,
                                                    input logic [IDX_W-1:0] idx);
        logic [REC_W-1:0] ra;
        logic [REC_W-1:0] rb;
        logic [WORD_W-1:0] w;
        ra = a;
        rb = b;
        case (idx)
            IDX_W'(0): w = ra[WORD_W-1:0];
            IDX_W'(1): w = ra[SPLIT_LO-1:WORD_W];
            IDX_W'(2): w = {{PAD_W{1'b0}}, rb[REC_W-1:SPLIT_LO], ra[REC_W-1:SPLIT_LO]};
            IDX_W'(3): w = rb[WORD_W-1:0];
            default:   w = rb[SPLIT_LO-1:WORD_W];
        endcase
        return w;
    endfunction
endpackage

// File: rtl/fmx_sync.sv
module fmx_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fmx_wr.sv
module fmx_wr
    import fmx_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   test_mode,
    input  logic [N_CH*CODE_W-1:0] code,
    input  logic [CAP_W-1:0]       capid,
    input  logic [HDR_W-1:0]       hdr,
    input  logic [AW-1:0]          rpair_gray_s,
    output logic                   we,
    output logic [AW-1:0]          waddr,
    output rec_t                   wrec,
    output logic [AW:0]            wgray,
    output logic                   ovf
);
    localparam logic [AW:0] DEPTH = (AW+1)'(1 << AW);

    typedef struct packed {
        logic [AW:0]       wbin;
        logic [AW:0]       wgray;
        logic [CODE_W-1:0] cnt;
        logic              ovf;
    } wst_t;

    wst_t s_q, s_d;
    logic [AW-1:0] rpair_bin;
    logic [AW:0]   fill;
    logic          full;

    function automatic logic [AW-1:0] g2b(input logic [AW-1:0] g);
        logic [AW-1:0] b;
        b[AW-1] = g[AW-1];
        for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        rpair_bin = g2b(rpair_gray_s);
        fill      = s_q.wbin - {rpair_bin, 1'b0};
        full      = (fill == DEPTH);

        wrec.hdr = hdr;
        for (int c = 0; c < N_CH; c++) begin
            wrec.data[c*CODE_W +: CODE_W] = test_mode ? s_q.cnt + CODE_W'(c)
                                                      : code[c*CODE_W +: CODE_W];
        end
        wrec.data[DATA_W-1 -: CAP_W] = test_mode ? s_q.cnt[CAP_W-1:0] : capid;

        s_d     = s_q;
        s_d.cnt = s_q.cnt + 1'b1;
        we      = !full;
        if (full) begin
            s_d.ovf = 1'b1;
        end else begin
            s_d.wbin  = s_q.wbin + 1'b1;
            s_d.wgray = s_d.wbin ^ (s_d.wbin >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign waddr = s_q.wbin[AW-1:0];
    assign wgray = s_q.wgray;
    assign ovf   = s_q.ovf;

    AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> $stable(s_q.wbin)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf |=> s_q.ovf); // R7
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH); // R3
endmodule

// File: rtl/fmx_store.sv
module fmx_store
    import fmx_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rec_t          wrec,
    input  logic [AW-2:0] rpair,
    output rec_t          rec_a,
    output rec_t          rec_b
);
    localparam int DEPTH = 1 << AW;

    rec_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wrec;
    end

    assign rec_a = mem_q[{rpair, 1'b0}];
    assign rec_b = mem_q[{rpair, 1'b1}];
endmodule

// File: rtl/fmx_rd.sv
module fmx_rd
    import fmx_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW:0]       wgray_s,
    input  rec_t              rec_a,
    input  rec_t              rec_b,
    output logic [AW-2:0]     rpair_addr,
    output logic [AW-1:0]     rgray,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    localparam logic [AW:0]      ONE_PAIR  = (AW+1)'(2);
    localparam logic [AW:0]      TWO_PAIRS = (AW+1)'(4);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_WORDS - 1);

    typedef struct packed {
        logic [AW-1:0]     rpair;
        logic [AW-1:0]     rgray;
        logic              busy;
        logic [IDX_W-1:0]  widx;
        logic [WORD_W-1:0] word;
        logic              valid;
    } rst_t;

    rst_t s_q, s_d;
    logic [AW:0] wbin;
    logic [AW:0] avail;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        wbin  = g2b(wgray_s);
        avail = wbin - {s_q.rpair, 1'b0};

        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.word  = '0;
        if (s_q.busy) begin
            s_d.valid = 1'b1;
            s_d.word  = pick_word(rec_a, rec_b, s_q.widx);
            if (s_q.widx == LAST_IDX) begin
                s_d.rpair = s_q.rpair + 1'b1;
                s_d.rgray = s_d.rpair ^ (s_d.rpair >> 1);
                s_d.widx  = '0;
                s_d.busy  = (avail >= TWO_PAIRS);
            end else begin
                s_d.widx = s_q.widx + 1'b1;
            end
        end else if (avail >= ONE_PAIR) begin
            s_d.busy = 1'b1;
            s_d.widx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rpair_addr = s_q.rpair[AW-2:0];
    assign rgray      = s_q.rgray;
    assign word       = s_q.word;
    assign valid      = s_q.valid;

    AST_START_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> avail >= ONE_PAIR); // R8
    AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rpair != $past(s_q.rpair)) |-> (s_q.rpair == $past(s_q.rpair) + 1'b1)); // R3
    AST_VALID_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> s_q.valid); // R2
endmodule

// File: rtl/frame_mux.sv
module frame_mux
    import fmx_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   sys_clk,
    input  logic                   sys_rst_n,
    input  logic                   test_mode,
    input  logic [N_CH*CODE_W-1:0] smp_code,
    input  logic [CAP_W-1:0]       smp_capid,
    input  logic [HDR_W-1:0]       smp_hdr,
    output logic                   ovf_flag,
    input  logic                   ser_clk,
    input  logic                   ser_rst_n,
    output logic [WORD_W-1:0]      ser_word,
    output logic                   ser_valid
);
    logic              we;
    logic [ADDR_W-1:0] waddr;
    rec_t              wrec;
    logic [ADDR_W:0]   wgray, wgray_s;
    logic [ADDR_W-1:0] rgray, rgray_s;
    logic [ADDR_W-2:0] rpair_addr;
    rec_t              rec_a, rec_b;

    fmx_wr #(.AW(ADDR_W)) u_wr (
        .clk(sys_clk), .rst_n(sys_rst_n), .test_mode(test_mode),
        .code(smp_code), .capid(smp_capid), .hdr(smp_hdr),
        .rpair_gray_s(rgray_s), .we(we), .waddr(waddr), .wrec(wrec),
        .wgray(wgray), .ovf(ovf_flag)
    );

    fmx_store #(.AW(ADDR_W)) u_store (
        .clk(sys_clk), .we(we), .waddr(waddr), .wrec(wrec),
        .rpair(rpair_addr), .rec_a(rec_a), .rec_b(rec_b)
    );

    fmx_sync #(.W(ADDR_W + 1), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk(ser_clk), .rst_n(ser_rst_n), .d(wgray), .q(wgray_s)
    );

    fmx_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk(sys_clk), .rst_n(sys_rst_n), .d(rgray), .q(rgray_s)
    );

    fmx_rd #(.AW(ADDR_W)) u_rd (
        .clk(ser_clk), .rst_n(ser_rst_n), .wgray_s(wgray_s),
        .rec_a(rec_a), .rec_b(rec_b), .rpair_addr(rpair_addr),
        .rgray(rgray), .word(ser_word), .valid(ser_valid)
    );

    AST_IDLE_WORD_ZERO: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
        !ser_valid |-> ser_word == '0); // R4
endmodule

// File: tb/frame_mux_bench.sv
module frame_mux_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        sys_clk = 1'b0;
    logic        ser_clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        ser_rst_n = 1'b0;
    logic        test_mode = 1'b0;
    logic [55:0] smp_code;
    logic [1:0]  smp_capid;
    logic [13:0] smp_hdr;
    logic        ovf_flag;
    logic [31:0] ser_word;
    logic        ser_valid;

    int checks = 0;
    int errors = 0;
    int kin = 0;
    int tmode = 0;
    int pos = 0;
    int fidx = 0;
    int max_frames = 1000;

    always #4 ser_clk = ~ser_clk;
    always #10.5 sys_clk = ~sys_clk;

    frame_mux u_frame_mux (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .test_mode(test_mode),
        .smp_code(smp_code), .smp_capid(smp_capid), .smp_hdr(smp_hdr),
        .ovf_flag(ovf_flag), .ser_clk(ser_clk), .ser_rst_n(ser_rst_n),
        .ser_word(ser_word), .ser_valid(ser_valid)
    );

    function automatic logic [6:0] code_of(int k, int c);
        return 7'((k * 5 + c * 13 + 3) & 127);
    endfunction

    function automatic logic [71:0] rec_of(int k, int tm);
        logic [71:0] r;
        for (int c = 0; c < 8; c++)
            r[c*7 +: 7] = (tm != 0) ? 7'((k + c) & 127) : code_of(k, c);
        r[57:56] = (tm != 0) ? 2'(k & 3) : 2'((k ^ 1) & 3);
        r[71:58] = 14'((k * 613 + 77) & 16383);
        return r;
    endfunction

    function automatic logic [31:0] exp_word(int f, int p, int tm);
        logic [71:0] a;
        logic [71:0] b;
        a = rec_of(2 * f, tm);
        b = rec_of(2 * f + 1, tm);
        case (p)
            0: return a[31:0];
            1: return a[63:32];
            2: return {16'h0, b[71:64], a[71:64]};
            3: return b[31:0];
            default: return b[63:32];
        endcase
    endfunction

    always_comb begin
        for (int c = 0; c < 8; c++) smp_code[c*7 +: 7] = code_of(kin, c);
        smp_capid = 2'((kin ^ 1) & 3);
        smp_hdr   = 14'((kin * 613 + 77) & 16383);
    end

    always @(posedge sys_clk) begin
        #1;
        if (!sys_rst_n) kin = 0;
        else            kin = kin + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Output monitor: R1, R2, R3, R4, R6
    always @(negedge ser_clk) begin
        if (!ser_rst_n) begin
            pos  = 0;
            fidx = 0;
        end else if (ser_valid) begin
            if (fidx < max_frames) begin
                logic [31:0] e;
                e = exp_word(fidx, pos, tmode);
                check(ser_word == e, (tmode != 0) ? "R6 test pattern" : "R1/R3 frame word",
                      ser_word, e);
            end
            pos++;
            if (pos == 5) begin
                pos = 0;
                fidx++;
            end
        end else begin
            check(pos == 0, "R2 gap inside frame", 32'(pos), 32'd0);
            check(ser_word == 32'h0, "R4 idle word", ser_word, 32'h0);
        end
    end

    task automatic reset_both();
        @(negedge sys_clk);
        sys_rst_n = 1'b0;
        ser_rst_n = 1'b0;
        repeat (4) @(negedge sys_clk);
    endtask

    initial begin
        // R5 reset state
        repeat (4) @(negedge sys_clk);
        check(ser_valid == 1'b0, "R5 valid in reset", 32'(ser_valid), 32'd0);
        check(ser_word == 32'h0, "R5 word in reset", ser_word, 32'h0);
        check(ovf_flag == 1'b0, "R5 overflow in reset", 32'(ovf_flag), 32'd0);

        // Phase 1: normal data, R1 R3
        max_frames = 1000;
        sys_rst_n = 1'b1;
        @(negedge ser_clk);
        ser_rst_n = 1'b1;
        check(ser_valid == 1'b0, "R5 idle right after reset", 32'(ser_valid), 32'd0);
        wait (fidx == 40);
        check(ovf_flag == 1'b0, "R3 no overflow at nominal rate", 32'(ovf_flag), 32'd0);

        // Phase 2: test mode, R6
        reset_both();
        test_mode = 1'b1;
        tmode = 1;
        sys_rst_n = 1'b1;
        @(negedge ser_clk);
        ser_rst_n = 1'b1;
        wait (fidx == 20);

        // Phase 3: reads stalled, R7
        reset_both();
        test_mode = 1'b0;
        tmode = 0;
        max_frames = 4;
        sys_rst_n = 1'b1;
        repeat (8) @(posedge sys_clk);
        @(negedge sys_clk);
        check(ovf_flag == 1'b0, "R7 eight records fit", 32'(ovf_flag), 32'd0);
        check(ser_valid == 1'b0, "R5 idle while reader in reset", 32'(ser_valid), 32'd0);
        @(posedge sys_clk);
        @(negedge sys_clk);
        check(ovf_flag == 1'b1, "R7 ninth write overflows", 32'(ovf_flag), 32'd1);
        @(negedge ser_clk);
        ser_rst_n = 1'b1;
        wait (fidx == 4);
        repeat (10) @(negedge sys_clk);
        check(ovf_flag == 1'b1, "R7 overflow sticky", 32'(ovf_flag), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule